// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This block produces a quick estimate of 1/sqrt(x) for a single-precision floating-point operand. A multiply-add datapath uses it as the seed for a division-free refinement loop, or uses it alone where about twelve correct bits are enough. An operand presented with its valid strobe gives an estimate one clock later. There is no handshake and no backpressure.

The result exponent comes from the input exponent by subtraction and halving. The result significand comes from a compressed table. The table is addressed by the parity of the unbiased exponent and the leading significand bits. Each entry holds a coarse base value and a narrow slope. The slope is scaled by the next significand bits, and the product is subtracted from the base to correct the low-order bits.

Zero, infinity, NaN and negative operands return fixed codes. Subnormal operands are flushed to zero. The rounding mode is ignored and no exception flags exist.

Top module: `rsqrt_est`

## Requirements
- R1: While `rst_n` is low, `out_vld` is 0 and `out_res` is 32'h0000_0000, and this holds from the moment reset is asserted.
- R2: `out_vld` in a cycle equals `in_vld` of the previous cycle, and the estimate for an operand appears on `out_res` one clock after that operand is presented.
- R3: A cycle with `in_vld` low leaves `out_res` unchanged, whatever `in_op` carries.
- R4: For a positive normal operand the result is a positive normal number with relative error below 2^-11 against 1/sqrt(x).
- R5: Adding 2 to the biased exponent of a positive normal operand (multiplying it by four) lowers the biased exponent of the result by exactly 1. The result's sign and 23-bit significand field stay the same.
- R6: An operand of the form 4^k, with a zero significand field and an even unbiased exponent, returns exactly 2^-k. For example 1.0 gives 32'h3F80_0000, 4.0 gives 32'h3F00_0000, 0.25 gives 32'h4000_0000 and 2^-126 gives 32'h5F00_0000.
- R7: +0 and -0 both return +infinity, 32'h7F80_0000.
- R8: Any operand with biased exponent field 0 (bits 30:23) is treated as zero, including a negative one, and returns 32'h7F80_0000.
- R9: +infinity (32'h7F80_0000) returns +0, 32'h0000_0000.
- R10: A negative operand with a nonzero exponent field, including -infinity, returns the quiet NaN 32'h7FC0_0000.
- R11: Any NaN operand (exponent field all ones, nonzero significand field), of either sign, returns 32'h7FC0_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand strobe; also the clock enable of the result register |
| in_op | input | 32 | Single-precision operand |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_res | output | 32 | Single-precision estimate of 1/sqrt(in_op) |

## Verification
The bench builds the block with its default parameters: six leading significand bits plus exponent parity address a 128-entry table, and eight further bits drive the slope correction. With these values the 2^-11 error bound is met only when the correction term is active, so a broken slope path or a wrong table half shows up in the tolerance checks. Exact powers of four land on the one table point whose value is 2.0, which exercises the carry into the exponent. Scaling pairs separate the exponent path from the significand path.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int BIAS  = 127;
  // fraction bits of the fixed-point table values (value range [1,2])
  localparam int FX    = 16;

  localparam logic [FP_W-1:0] POS_INF = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [FP_W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } cls_e;

  // integer square root, floor
  function automatic longint unsigned isqrt(input longint unsigned a);
    longint unsigned rem;
    longint unsigned res;
    longint unsigned bt;
    rem = a;
    res = 0;
    bt  = 64'd1 << 62;
    while (bt > rem) bt = bt >> 2;
    while (bt != 0) begin
      if (rem >= res + bt) begin
        rem = rem - (res + bt);
        res = (res >> 1) + bt;
      end else begin
        res = res >> 1;
      end
      bt = bt >> 2;
    end
    return res;
  endfunction

  // 2/sqrt(r) in 1.FX fixed point, r = (2^mi + k)/2^mi, doubled when odd is set
  function automatic longint unsigned rsq_point(input int mi, input bit odd, input int k);
    longint unsigned num;
    longint unsigned den;
    num = 64'd1 << (2*FX + 2 + mi - (odd ? 1 : 0));
    den = (64'd1 << mi) + longint'(k);
    return isqrt(num / den);
  endfunction

endpackage

// File: rtl/rsqrt_classify.sv
module rsqrt_classify
  import rsqrt_pkg::*;
(
  input  logic [FP_W-1:0] op,
  output cls_e            cls
);
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;

  assign ex = op[FP_W-2 -: EXP_W];
  assign mn = op[MAN_W-1:0];

  // priority: NaN, then zero/subnormal (flushed), then sign, then infinity
  always_comb begin
    if (ex == '1 && mn != '0)  cls = CLS_NAN;
    else if (ex == '0)         cls = CLS_ZERO;
    else if (op[FP_W-1])       cls = CLS_NAN;
    else if (ex == '1)         cls = CLS_INF;
    else                       cls = CLS_NORM;
  end
endmodule

// File: rtl/rsqrt_exp.sv
module rsqrt_exp
  import rsqrt_pkg::*;
(
  input  logic [EXP_W-1:0] e_in,
  input  logic             carry,
  output logic [EXP_W-1:0] e_out
);
  // (3*bias - 1 - E) / 2 covers both parities with one floor shift
  localparam int         K_OFF = 3*BIAS - 1;
  localparam int         DW    = EXP_W + 2;

  logic [DW-1:0] diff;
  logic          unused_diff;

  assign diff        = DW'(K_OFF) - {2'b00, e_in};
  assign e_out       = diff[EXP_W:1] + EXP_W'(carry);
  assign unused_diff = diff[0] ^ diff[DW-1];
endmodule

// File: rtl/rsqrt_mant_rom.sv
module rsqrt_mant_rom
  import rsqrt_pkg::*;
#(
  parameter int MI_BITS = 6,
  parameter int IP_BITS = 8
) (
  input  logic             odd,
  input  logic [MAN_W-1:0] man,
  output logic [MAN_W-1:0] man_out,
  output logic             carry
);
  localparam int HALF   = 1 << MI_BITS;
  localparam int ENT    = 2 * HALF;
  localparam int BASE_W = FX + 2;
  localparam int SL_W   = FX - MI_BITS + 1;
  localparam int PR_W   = SL_W + IP_BITS;
  localparam int LOW_W  = MAN_W - MI_BITS - IP_BITS;

  logic [BASE_W-1:0]  base_rom  [ENT];
  logic [SL_W-1:0]    slope_rom [ENT];
  logic [MI_BITS:0]   idx;
  logic [IP_BITS-1:0] frac;
  logic [PR_W-1:0]    prod;
  logic [SL_W-1:0]    corr;
  logic [BASE_W-1:0]  est;
  logic               unused_bits;

  // table halves: index MSB set means odd unbiased exponent, range [2,4)
  for (genvar g = 0; g < ENT; g++) begin : g_rom
    localparam longint unsigned B0 = rsq_point(MI_BITS, g >= HALF, g % HALF);
    localparam longint unsigned B1 = rsq_point(MI_BITS, g >= HALF, (g % HALF) + 1);
    assign base_rom[g]  = BASE_W'(B0);
    assign slope_rom[g] = SL_W'(B0 - B1);
  end

  assign idx  = {odd, man[MAN_W-1 -: MI_BITS]};
  assign frac = man[MAN_W-MI_BITS-1 -: IP_BITS];
  assign prod = {{IP_BITS{1'b0}}, slope_rom[idx]} * {{SL_W{1'b0}}, frac};
  assign corr = prod[PR_W-1:IP_BITS];
  assign est  = base_rom[idx] - BASE_W'(corr);

  // est reaches 2.0 only at the exact start of the even half
  assign carry   = est[BASE_W-1];
  assign man_out = carry ? '0 : {est[FX-1:0], {(MAN_W-FX){1'b0}}};

  if (LOW_W > 0) begin : g_low
    assign unused_bits = ^{man[LOW_W-1:0], prod[IP_BITS-1:0], est[FX]};
  end else begin : g_nolow
    assign unused_bits = ^{prod[IP_BITS-1:0], est[FX]};
  end
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsqrt_pkg::*;
#(
  parameter int MI_BITS = 6,
  parameter int IP_BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [FP_W-1:0] in_op,
  output logic            out_vld,
  output logic [FP_W-1:0] out_res
);
  cls_e             cls;
  logic [EXP_W-1:0] e_in;
  logic [EXP_W-1:0] e_out;
  logic [MAN_W-1:0] m_out;
  logic             m_carry;
  logic [FP_W-1:0]  res_d;
  logic [FP_W-1:0]  res_q;
  logic             vld_q;

  assign e_in = in_op[FP_W-2 -: EXP_W];

  rsqrt_classify u_cls (
    .op  (in_op),
    .cls (cls)
  );

  rsqrt_mant_rom #(
    .MI_BITS (MI_BITS),
    .IP_BITS (IP_BITS)
  ) u_rom (
    .odd     (~e_in[0]),
    .man     (in_op[MAN_W-1:0]),
    .man_out (m_out),
    .carry   (m_carry)
  );

  rsqrt_exp u_exp (
    .e_in  (e_in),
    .carry (m_carry),
    .e_out (e_out)
  );

  always_comb begin
    unique case (cls)
      CLS_ZERO: res_d = POS_INF;
      CLS_INF:  res_d = '0;
      CLS_NAN:  res_d = QNAN;
      default:  res_d = {1'b0, e_out, m_out};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) res_q <= res_d;
    end
  end

  assign out_vld = vld_q;
  assign out_res = res_q;

  p_vld_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  p_vld_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_res));
  p_norm_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_op[FP_W-1] && in_op[30:23] != 8'h00 && in_op[30:23] != 8'hFF)
      |=> (!out_res[FP_W-1] && out_res[30:23] >= 8'd63 && out_res[30:23] <= 8'd190));
  p_zero_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op[30:23] == 8'h00) |=> (out_res == POS_INF));
  p_inf_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == POS_INF) |=> (out_res == '0));
  p_neg_nan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op[FP_W-1] && in_op[30:23] != 8'h00) |=> (out_res == QNAN));
endmodule

// File: tb/tb_rsqrt_est.sv
`timescale 1ns/1ps
module tb_rsqrt_est;
  localparam int NV = 23;
  localparam logic [31:0] APPROX = 32'hFFFF_FFFF;

  localparam logic [31:0] VIN [NV] = '{
    32'h3F80_0000, 32'h4080_0000, 32'h3E80_0000, 32'h0080_0000,  // R6
    32'h0000_0000, 32'h8000_0000,                                // R7
    32'h0000_0001, 32'h807F_FFFF,                                // R8
    32'h7F80_0000,                                               // R9
    32'hFF80_0000, 32'hBF80_0000, 32'hC2F6_E979,                 // R10
    32'h7FC0_0000, 32'h7F80_0001, 32'hFFFF_FFFF,                 // R11
    32'h4000_0000, 32'h3FC0_0000, 32'h4049_0FDB, 32'h7F7F_FFFF,  // R4
    32'h3F7F_FFFF, 32'h42F6_E979, 32'h3DCC_CCCD, 32'h00FF_FFFF
  };
  localparam logic [31:0] VEXP [NV] = '{
    32'h3F80_0000, 32'h3F00_0000, 32'h4000_0000, 32'h5F00_0000,
    32'h7F80_0000, 32'h7F80_0000,
    32'h7F80_0000, 32'h7F80_0000,
    32'h0000_0000,
    32'h7FC0_0000, 32'h7FC0_0000, 32'h7FC0_0000,
    32'h7FC0_0000, 32'h7FC0_0000, 32'h7FC0_0000,
    APPROX, APPROX, APPROX, APPROX,
    APPROX, APPROX, APPROX, APPROX
  };
  localparam int VTAG [NV] = '{6,6,6,6, 7,7, 8,8, 9, 10,10,10, 11,11,11, 4,4,4,4, 4,4,4,4};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [31:0] in_op;
  logic        out_vld;
  logic [31:0] out_res;
  int          checks = 0;
  int          failures = 0;

  always #10 clk = ~clk;

  rsqrt_est dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_op   (in_op),
    .out_vld (out_vld),
    .out_res (out_res)
  );

  function automatic real f2r(input logic [31:0] b);
    logic [63:0] d;
    if (b[30:23] == 8'h00) return 0.0;
    d = {b[31], 11'(int'(b[30:23]) - 127 + 1023), b[22:0], 29'd0};
    return $bitstoreal(d);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic chk_approx(input logic [31:0] op, input logic [31:0] act);
    real ref_v;
    real got;
    real err;
    checks++;
    ref_v = 1.0 / $sqrt(f2r(op));
    got   = f2r(act);
    err   = (got - ref_v) / ref_v;
    if (err < 0.0) err = -err;
    if (act[31] || act[30:23] == 8'h00 || act[30:23] == 8'hFF || err >= 2.0**(-11)) begin
      failures++;
      $display("FAIL R4 op=%h actual=%h (%g) expected~%g relerr=%g", op, act, got, ref_v, err);
    end
  endtask

  // present one operand at a falling edge, sample at the next falling edge
  task automatic apply(input logic [31:0] op);
    in_vld = 1'b1;
    in_op  = op;
    @(negedge clk);
    chk("R2 out_vld", {31'd0, out_vld}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r_a;
    logic [31:0] held;
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_op  = 32'h3F80_0000;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 out_vld", {31'd0, out_vld}, 32'd0);
    chk("R1 out_res", out_res, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle out_vld", {31'd0, out_vld}, 32'd0);

    // vector walk: R4, R6, R7, R8, R9, R10, R11
    for (int i = 0; i < NV; i++) begin
      apply(VIN[i]);
      if (VEXP[i] == APPROX) chk_approx(VIN[i], out_res);
      else chk($sformatf("R%0d op=%h", VTAG[i], VIN[i]), out_res, VEXP[i]);
    end

    // R3: hold while in_vld is low, R2: strobe drops
    apply(32'h4049_0FDB);
    held   = out_res;
    in_vld = 1'b0;
    in_op  = 32'h0000_0000;
    @(negedge clk);
    chk("R2 out_vld low", {31'd0, out_vld}, 32'd0);
    chk("R3 hold", out_res, held);
    in_op = 32'h7F80_0000;
    @(negedge clk);
    chk("R3 hold 2", out_res, held);

    // R5: multiply by four lowers exponent by one, same significand
    foreach (VIN[i]) begin
      if (VEXP[i] == APPROX && VIN[i][30:23] < 8'd250) begin
        apply(VIN[i]);
        r_a = out_res;
        apply(VIN[i] + 32'h0100_0000);
        chk($sformatf("R5 op=%h", VIN[i]), out_res, r_a - 32'h0080_0000);
      end
    end

    // R1: asynchronous reset mid-run
    apply(32'h3FC0_0000);
    #3 rst_n = 1'b0;
    #2;
    chk("R1 async out_vld", {31'd0, out_vld}, 32'd0);
    chk("R1 async out_res", out_res, 32'd0);
    in_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    apply(32'h4080_0000);
    chk("R6 after reset", out_res, 32'h3F00_0000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule